// File: doc/BRIEF.md
# Bidirectional Port Controller with Toggle Writes

This block controls a byte-wide group of general-purpose pads. Software reaches it through a small synchronous register bus that has three live slots. The direction slot picks, per bit, whether the pad is driven or only sensed. The data slot holds the level that driven pads put out. On a sensed pad the same data bit asks for a weak pull-up instead. The pin slot returns the level on the pad after a two-flop synchronizer. A bit reads back even when the block itself is driving that pad.

Writing to the pin slot does not store anything. Each one bit in the written byte flips the matching data bit, and each zero bit leaves it alone. Software can therefore flip single pads without a read-modify-write. A global pull-up kill input comes from a control register elsewhere in the chip. It switches off every pull-up that the data bits request.

Top module: `gpio_toggle_port`

## Requirements
- R1: While reset is held, and right after it, direction and data are all zero. Every pad then has output enable 0, output value 0 and pull-up 0. The read data register is also zero.
- R2: The bus slot is chosen by `bus_addr`: 0 = pin, 1 = direction, 2 = data, 3 = unused. A cycle with `bus_sel`=1 and `bus_we`=1 stores `bus_wdata` into direction (slot 1) or data (slot 2).
- R3: A write to slot 0 inverts every data bit whose `bus_wdata` bit is 1 and leaves the other data bits unchanged. This holds whatever the direction bits are. The direction register is not changed.
- R4: A pad whose direction bit is 1 has output enable 1, output value equal to its data bit, and pull-up 0.
- R5: A pad whose direction bit is 0 and data bit is 0 has output enable 0, output value 0 and pull-up 0, whatever `pu_disable` is.
- R6: A pad whose direction bit is 0 and data bit is 1 has pull-up 1 when `pu_disable` is 0 and pull-up 0 when `pu_disable` is 1. Output enable and output value are 0.
- R7: A read of slot 0 returns the pad level for all bits, whatever the direction bits are. The level passes through two flip-flops. A value on `pad_in` at rising edge k is returned by a read whose request is sampled at edge k+2, and not by one sampled at edge k+1.
- R8: A read request (`bus_sel`=1, `bus_we`=0) sampled at a rising edge puts the slot's contents on `bus_rdata` right after that edge. `bus_rdata` holds that value until the next read. Slot 3 reads as zero, and a write to slot 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access request in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Slot: 0 pin, 1 direction, 2 data, 3 unused |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |
| pu_disable | input | 1 | Global pull-up kill |
| pad_in | input | WIDTH | Raw asynchronous pad levels |
| pad_oe | output | WIDTH | Per-pad driver enable |
| pad_out | output | WIDTH | Per-pad driven level |
| pad_pu | output | WIDTH | Per-pad pull-up enable |

## Verification
The bench builds the block with its defaults: WIDTH of 8 and a synchronizer depth of 2. At that width a single direction/data pattern puts all four direction/data pairings on different bits at once. Toggling `pu_disable` then covers every pull-up case in two cycles. The depth of 2 lets a cycle-by-cycle model pin down the exact cycle in which a pad change becomes readable. The model also covers back-to-back reads while the pads change every cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        SLOT_PIN  = 2'd0,
        SLOT_DIR  = 2'd1,
        SLOT_DATA = 2'd2,
        SLOT_NONE = 2'd3
    } gpio_slot_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] synced
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
    } sync_t;

    sync_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.stage[0] = raw_in;
        for (int s = 1; s < STAGES; s++) begin
            state_d.stage[s] = state_q.stage[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign synced = state_q.stage[LAST];

    a_r7_first_stage_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (state_q.stage[0] == $past(raw_in)));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  gpio_slot_e       slot,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] data_q
);

    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] data;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (slot)
                SLOT_PIN:  regs_d.data = regs_q.data ^ wdata;
                SLOT_DIR:  regs_d.dir  = wdata;
                SLOT_DATA: regs_d.data = wdata;
                default:   regs_d      = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign dir_q  = regs_q.dir;
    assign data_q = regs_q.data;

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (dir_q == '0 && data_q == '0));

    a_r3_toggle_flips_ones: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_en) && $past(slot) == SLOT_PIN
        |-> (data_q == ($past(data_q) ^ $past(wdata))) && $stable(dir_q));

    a_r8_unused_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_en) && $past(slot) == SLOT_NONE
        |-> $stable(dir_q) && $stable(data_q));

endmodule

// File: rtl/gpio_padctl.sv
module gpio_padctl #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] data,
    input  logic             pu_disable,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_comb begin
            pad_oe[b]  = dir[b];
            pad_out[b] = dir[b] & data[b];
            pad_pu[b]  = ~dir[b] & data[b] & ~pu_disable;
        end
    end

    a_r4_no_pull_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_pu) == '0);

    a_r6_kill_clears_pulls: assert property (@(posedge clk) disable iff (!rst_n)
        pu_disable |-> pad_pu == '0);

endmodule

// File: rtl/gpio_toggle_port.sv
module gpio_toggle_port
    import gpio_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic             pu_disable,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu
);

    typedef struct packed {
        logic [WIDTH-1:0] rdata;
    } rd_t;

    logic             rd_en;
    logic             wr_en;
    gpio_slot_e       slot;
    logic [WIDTH-1:0] pin_val;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] data_q;
    rd_t              rd_d, rd_q;

    assign rd_en = bus_sel & ~bus_we;
    assign wr_en = bus_sel & bus_we;
    assign slot  = gpio_slot_e'(bus_addr);

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (pad_in),
        .synced (pin_val)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .slot   (slot),
        .wdata  (bus_wdata),
        .dir_q  (dir_q),
        .data_q (data_q)
    );

    gpio_padctl #(.WIDTH(WIDTH)) u_pad (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir        (dir_q),
        .data       (data_q),
        .pu_disable (pu_disable),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out),
        .pad_pu     (pad_pu)
    );

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            unique case (slot)
                SLOT_PIN:  rd_d.rdata = pin_val;
                SLOT_DIR:  rd_d.rdata = dir_q;
                SLOT_DATA: rd_d.rdata = data_q;
                default:   rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rdata = rd_q.rdata;

    a_r8_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(rd_en) |-> $stable(bus_rdata));

    a_r8_slot3_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(rd_en) && $past(bus_addr) == 2'd3 |-> bus_rdata == '0);

    a_r2_dir_readback: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(rd_en) && $past(bus_addr) == 2'd1 |-> bus_rdata == $past(dir_q));

    if (SYNC_STAGES == 2) begin : g_lat_chk
        logic [1:0] warm_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                warm_q <= '0;
            end else if (warm_q != 2'd3) begin
                warm_q <= warm_q + 2'd1;
            end
        end
        a_r7_two_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
            warm_q == 2'd3 |-> pin_val == $past(pad_in, 2));
    end

endmodule

// File: tb/gpio_toggle_port_test.sv
module gpio_toggle_port_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         bus_sel;
    logic         bus_we;
    logic [1:0]   bus_addr;
    logic [W-1:0] bus_wdata;
    logic [W-1:0] bus_rdata;
    logic         pu_disable;
    logic [W-1:0] pad_in;
    logic [W-1:0] pad_oe;
    logic [W-1:0] pad_out;
    logic [W-1:0] pad_pu;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string cur_tag = "R1";

    logic [W-1:0] m_dir, m_data, m_s1, m_s2, m_rdata;

    always #5 clk = ~clk;

    gpio_toggle_port uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pu_disable (pu_disable),
        .pad_in     (pad_in),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out),
        .pad_pu     (pad_pu)
    );

    // Behavioural reference model, one update per rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dir = '0; m_data = '0; m_s1 = '0; m_s2 = '0; m_rdata = '0;
        end else begin
            if (bus_sel && !bus_we) begin
                case (bus_addr)
                    2'd0: m_rdata = m_s2;
                    2'd1: m_rdata = m_dir;
                    2'd2: m_rdata = m_data;
                    default: m_rdata = '0;
                endcase
            end
            if (bus_sel && bus_we) begin
                case (bus_addr)
                    2'd0: m_data = m_data ^ bus_wdata;
                    2'd1: m_dir  = bus_wdata;
                    2'd2: m_data = bus_wdata;
                    default: ;
                endcase
            end
            m_s2 = m_s1;
            m_s1 = pad_in;
        end
    end

    task automatic cmp(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", cur_tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        logic [W-1:0] e_pu;
        e_pu = ~m_dir & m_data & {W{~pu_disable}};
        cmp("pad_oe",    pad_oe,    m_dir);
        cmp("pad_out",   pad_out,   m_dir & m_data);
        cmp("pad_pu",    pad_pu,    e_pu);
        cmp("bus_rdata", bus_rdata, m_rdata);
    endtask

    task automatic cyc(input logic sel, input logic we, input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        check_all();
        bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d;
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        cyc(1'b1, 1'b1, a, d);
    endtask

    task automatic rd(input logic [1:0] a);
        cyc(1'b1, 1'b0, a, '0);
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 2'd0, '0);
    endtask

    initial begin
        rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0;
        bus_wdata = '0; pu_disable = 1'b0; pad_in = 8'hA7;
        // R1: reset state, all pads high-impedance inputs
        cur_tag = "R1";
        idle(); idle();
        rst_n = 1'b1;
        idle(); idle();

        // R2: plain stores and readback; R8 one-cycle read latency
        cur_tag = "R2";
        wr(2'd1, 8'h5A); wr(2'd2, 8'hC3); rd(2'd1); rd(2'd2); idle(); idle();

        // R3: toggle writes, under several direction settings
        cur_tag = "R3";
        wr(2'd1, 8'h00); wr(2'd2, 8'h0F);
        wr(2'd0, 8'hFF); rd(2'd2);
        wr(2'd0, 8'h00); rd(2'd2);
        wr(2'd1, 8'hFF); wr(2'd0, 8'hA5); rd(2'd2); rd(2'd1);
        wr(2'd1, 8'h3C); wr(2'd0, 8'h81); wr(2'd0, 8'h81); rd(2'd2); rd(2'd1); idle();

        // R4 R5 R6: every direction/data pairing with both pull-up kill values
        cur_tag = "R4_R5_R6";
        wr(2'd1, 8'h0F); wr(2'd2, 8'h33); idle();
        pu_disable = 1'b1; idle(); idle();
        pu_disable = 1'b0; idle();
        for (int p = 0; p < 16; p++) begin
            wr(2'd1, W'(p * 37)); wr(2'd2, W'(p * 91 + 5));
            pu_disable = p[0]; idle();
            pu_disable = ~p[0]; idle();
        end
        pu_disable = 1'b0;

        // R7: pin reads, exact latency, independent of direction
        cur_tag = "R7";
        wr(2'd1, 8'h00);
        pad_in = 8'h96; rd(2'd0); rd(2'd0); rd(2'd0); rd(2'd0);
        wr(2'd1, 8'hFF);
        pad_in = 8'h69; rd(2'd0); rd(2'd0); rd(2'd0); idle();
        for (int k = 0; k < 12; k++) begin
            pad_in = W'(k * 29 + 3);
            rd(2'd0);
        end
        idle(); idle();

        // R8: unused slot, and toggles leave direction alone
        cur_tag = "R8";
        wr(2'd1, 8'h12); wr(2'd2, 8'h34);
        wr(2'd3, 8'hFF); rd(2'd1); rd(2'd2); rd(2'd3); idle();
        wr(2'd0, 8'hF0); rd(2'd1); rd(2'd2); idle();

        // R1: reset again from a busy state
        cur_tag = "R1";
        @(negedge clk); rst_n = 1'b0;
        idle(); rst_n = 1'b1; idle(); idle();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule